// File: doc/BRIEF.md
# Mailbox Bus Bridge

The bridge gives host software one 32-bit mailbox word through which it reaches up to eight byte-wide peripherals on a local bus. Each peripheral exposes up to eight registers. Software fills in a peripheral number, a register index, a direction flag and, for writes, a data byte. It then waits for the busy flag in the same word to drop. When the flag drops, the bus transfer has finished. For reads, the data byte then holds the value returned by the peripheral.

The local bus is shared with a background code-write stream. This stream presents requests through a simple request/acknowledge pair. The bridge grants the bus only while it is idle. A mailbox request therefore slots in between two code-write transfers and never cuts one short. Each transfer has three phases: a select/setup phase, a strobe phase that the peripheral can stretch with a wait line, and a hold phase.

Top module: `mbx_bridge`

## Requirements
- R1: After reset, every chip select and both strobes are low, the data-bus enable is low, the code-write acknowledge is low and the mailbox word reads as all zeros.
- R2: The mailbox word holds the data byte in bits 7:0, the register index in 18:16, the peripheral number in 22:20 and the direction in bit 24 (1 = write, 0 = read). Bit 25 is the busy flag; it is read-only. A host write while busy is 0 loads the fields and sets busy to 1 on the next clock.
- R3: A host write that arrives while busy is 1 changes no field and starts no extra transfer.
- R4: Busy stays 1 until the transfer ends. It then returns to 0, which makes it 1 for exactly (strobe length + 4) clocks after the accepted write.
- R5: A transfer consists of exactly 2 clocks of setup, then a strobe of at least 4 clocks, then exactly 1 clock of hold. While the wait input is high, the strobe continues.
- R6: A write transfer pulses the write strobe and drives the data byte with the output enable high. A read transfer pulses the read strobe, and the output enable stays low throughout.
- R7: For a read, the byte on the data-bus input in the last strobe clock is placed in data-byte bits 7:0 by the time busy reads 0.
- R8: During a transfer, exactly one chip select is high, namely bit n for peripheral n, and the register address equals the register index.
- R9: A code-write transfer in progress when a mailbox request arrives completes first. The mailbox transfer then runs before the next code-write transfer, even if the code-write request stays high.
- R10: When both requests are present on the same idle clock, the mailbox request wins.
- R11: The code-write acknowledge pulses for one clock at the end of each code-write transfer and never at the end of a mailbox transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe for the mailbox word |
| host_wdata | input | 32 | Mailbox word written by the host |
| host_rdata | output | 32 | Mailbox word as read by the host, busy flag in bit 25 |
| cw_req | input | 1 | Background code-write request, held until acknowledged |
| cw_dev | input | 3 | Peripheral number for the code write |
| cw_reg | input | 3 | Register index for the code write |
| cw_data | input | 8 | Byte for the code write |
| cw_ack | output | 1 | One-clock pulse when a code-write transfer ends |
| lb_cs | output | 8 | One chip select per peripheral, active high |
| lb_addr | output | 3 | Register address on the local bus |
| lb_wr | output | 1 | Write strobe, active high |
| lb_rd | output | 1 | Read strobe, active high |
| lb_wait | input | 1 | Peripheral wait request, stretches the strobe while high |
| lb_din | input | 8 | Data bus, inbound half |
| lb_dout | output | 8 | Data bus, outbound half |
| lb_doe | output | 1 | Output enable for lb_dout |

## Verification
The bench targets several corner cases:
- A wait line held longer than the minimum strobe. A design that ignored it would cut the strobe at 4 clocks, and the read byte would land early.
- A second host write during a busy transfer. A leaky design would retarget the transfer or run a second one.
- Data-word bits outside the defined fields. These expose sloppy field decoding.
- A mailbox request raised while a code-write strobe is active and the code-write request stays asserted. A wrong arbiter would either abort the code write or let it run twice in a row.
- A tie on an idle clock. A wrong priority would serve the code write first.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DEV_W  = 3;
  localparam int RIX_W  = 3;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 32;
  localparam int N_DEV  = 1 << DEV_W;

  // mailbox word field positions
  localparam int F_DATA_LO = 0;
  localparam int F_RIX_LO  = 16;
  localparam int F_DEV_LO  = 20;
  localparam int F_DIR     = 24;
  localparam int F_BUSY    = 25;

  typedef enum logic [1:0] {
    BS_IDLE   = 2'd0,
    BS_SETUP  = 2'd1,
    BS_STROBE = 2'd2,
    BS_HOLD   = 2'd3
  } bus_st_t;

  typedef struct packed {
    logic              wr;
    logic [DEV_W-1:0]  dev;
    logic [RIX_W-1:0]  rix;
    logic [BYTE_W-1:0] data;
  } bus_op_t;
endpackage

// File: rtl/mbx_regs.sv
module mbx_regs
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              done_mbx,
  input  logic              done_rd,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              busy,
  output bus_op_t           op
);
  localparam logic [WORD_W-1:0] USED_MASK =
      (WORD_W'((1 << BYTE_W) - 1) << F_DATA_LO) |
      (WORD_W'((1 << RIX_W) - 1) << F_RIX_LO) |
      (WORD_W'((1 << DEV_W) - 1) << F_DEV_LO) |
      (WORD_W'(1) << F_DIR);

  logic unused_wbits;
  assign unused_wbits = ^(host_wdata & ~USED_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      op   <= '0;
    end else if (done_mbx) begin
      busy <= 1'b0;
      if (done_rd) op.data <= rd_byte;
    end else if (host_wr && !busy) begin
      op.data <= host_wdata[F_DATA_LO +: BYTE_W];
      op.rix  <= host_wdata[F_RIX_LO +: RIX_W];
      op.dev  <= host_wdata[F_DEV_LO +: DEV_W];
      op.wr   <= host_wdata[F_DIR];
      busy    <= 1'b1;
    end
  end

  always_comb begin
    host_rdata                      = '0;
    host_rdata[F_DATA_LO +: BYTE_W] = op.data;
    host_rdata[F_RIX_LO +: RIX_W]   = op.rix;
    host_rdata[F_DEV_LO +: DEV_W]   = op.dev;
    host_rdata[F_DIR]               = op.wr;
    host_rdata[F_BUSY]              = busy;
  end

  // R3: a write during busy leaves the request untouched
  assert_busy_ignores_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && host_wr && !done_mbx) |=> ($stable(op) && busy));

  // R4: busy is held until the transfer reports completion
  assert_busy_held_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !done_mbx) |=> busy);

  assert_done_needs_busy_R4: assert property (@(posedge clk) disable iff (rst)
    done_mbx |-> busy);
endmodule

// File: rtl/mbx_arb.sv
module mbx_arb (
  input  logic clk,
  input  logic rst,
  input  logic bus_idle,
  input  logic mbx_req,
  input  logic cw_req,
  output logic gnt_mbx,
  output logic gnt_cw
);
  always_comb begin
    gnt_mbx = bus_idle && mbx_req;
    gnt_cw  = bus_idle && cw_req && !mbx_req;
  end

  // R10: at most one grant, and a tie goes to the mailbox
  assert_single_grant_R10: assert property (@(posedge clk) disable iff (rst)
    !(gnt_mbx && gnt_cw));

  assert_tie_to_mailbox_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_idle && mbx_req && cw_req) |-> !gnt_cw);

  // R9: nothing is granted while a transfer runs
  assert_no_grant_busy_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_idle |-> !(gnt_mbx || gnt_cw));
endmodule

// File: rtl/mbx_buscycle.sv
module mbx_buscycle
  import mbx_pkg::*;
#(
  parameter int SETUP_CLKS = 2,
  parameter int STROBE_MIN = 4,
  parameter int HOLD_CLKS  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  bus_op_t           start_op,
  input  logic              start_mbx,
  output logic              bus_idle,
  output logic              done_mbx,
  output logic              done_rd,
  output logic              done_cw,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [N_DEV-1:0]  lb_cs,
  output logic [RIX_W-1:0]  lb_addr,
  output logic              lb_wr,
  output logic              lb_rd,
  input  logic              lb_wait,
  input  logic [BYTE_W-1:0] lb_din,
  output logic [BYTE_W-1:0] lb_dout,
  output logic              lb_doe
);
  localparam int MAXC  = (SETUP_CLKS > STROBE_MIN) ?
                         ((SETUP_CLKS > HOLD_CLKS) ? SETUP_CLKS : HOLD_CLKS) :
                         ((STROBE_MIN > HOLD_CLKS) ? STROBE_MIN : HOLD_CLKS);
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SETUP_CLKS - 1);
  localparam logic [CNT_W-1:0] STR_LAST = CNT_W'(STROBE_MIN - 1);
  localparam logic [CNT_W-1:0] HLD_LAST = CNT_W'(HOLD_CLKS - 1);

  bus_st_t          state;
  logic [CNT_W-1:0] cnt;
  bus_op_t          cur_op;
  logic             cur_mbx;
  logic             active;
  logic             done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= BS_IDLE;
      cnt     <= '0;
      cur_op  <= '0;
      cur_mbx <= 1'b0;
      rd_byte <= '0;
    end else begin
      case (state)
        BS_IDLE: begin
          if (start) begin
            cur_op  <= start_op;
            cur_mbx <= start_mbx;
            cnt     <= '0;
            state   <= BS_SETUP;
          end
        end
        BS_SETUP: begin
          if (cnt == SET_LAST) begin
            cnt   <= '0;
            state <= BS_STROBE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        BS_STROBE: begin
          if (cnt >= STR_LAST && !lb_wait) begin
            rd_byte <= lb_din;
            cnt     <= '0;
            state   <= BS_HOLD;
          end else if (cnt < STR_LAST) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == HLD_LAST) begin
            cnt   <= '0;
            state <= BS_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign active   = (state != BS_IDLE);
  assign bus_idle = !active;
  assign done     = (state == BS_HOLD) && (cnt == HLD_LAST);
  assign done_mbx = done && cur_mbx;
  assign done_rd  = done && cur_mbx && !cur_op.wr;
  assign done_cw  = done && !cur_mbx;

  for (genvar g = 0; g < N_DEV; g++) begin : g_cs
    assign lb_cs[g] = active && (cur_op.dev == DEV_W'(g));
  end

  assign lb_addr = active ? cur_op.rix : '0;
  assign lb_wr   = (state == BS_STROBE) && cur_op.wr;
  assign lb_rd   = (state == BS_STROBE) && !cur_op.wr;
  assign lb_doe  = active && cur_op.wr;
  assign lb_dout = lb_doe ? cur_op.data : '0;

  // R8: one peripheral at a time
  assert_cs_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lb_cs));

  // R6: strobes exclusive, bus not driven during a read
  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(lb_wr && lb_rd));

  assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (rst)
    lb_rd |-> !lb_doe);

  // R5: minimum strobe and wait stretching
  assert_strobe_min_R5: assert property (@(posedge clk) disable iff (rst)
    ((lb_wr || lb_rd) && cnt < STR_LAST) |=> (lb_wr || lb_rd));

  assert_wait_stretch_R5: assert property (@(posedge clk) disable iff (rst)
    ((lb_wr || lb_rd) && lb_wait) |=> (lb_wr || lb_rd));

  assert_cs_through_hold_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(lb_wr || lb_rd) |-> (lb_cs != '0));
endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge
  import mbx_pkg::*;
#(
  parameter int SETUP_CLKS = 2,
  parameter int STROBE_MIN = 4,
  parameter int HOLD_CLKS  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              cw_req,
  input  logic [DEV_W-1:0]  cw_dev,
  input  logic [RIX_W-1:0]  cw_reg,
  input  logic [BYTE_W-1:0] cw_data,
  output logic              cw_ack,
  output logic [N_DEV-1:0]  lb_cs,
  output logic [RIX_W-1:0]  lb_addr,
  output logic              lb_wr,
  output logic              lb_rd,
  input  logic              lb_wait,
  input  logic [BYTE_W-1:0] lb_din,
  output logic [BYTE_W-1:0] lb_dout,
  output logic              lb_doe
);
  logic              busy;
  bus_op_t           mbx_op;
  bus_op_t           cw_op;
  bus_op_t           sel_op;
  logic              bus_idle;
  logic              gnt_mbx;
  logic              gnt_cw;
  logic              done_mbx;
  logic              done_rd;
  logic              done_cw;
  logic [BYTE_W-1:0] rd_byte;

  mbx_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .done_mbx   (done_mbx),
    .done_rd    (done_rd),
    .rd_byte    (rd_byte),
    .busy       (busy),
    .op         (mbx_op)
  );

  mbx_arb u_arb (
    .clk      (clk),
    .rst      (rst),
    .bus_idle (bus_idle),
    .mbx_req  (busy),
    .cw_req   (cw_req),
    .gnt_mbx  (gnt_mbx),
    .gnt_cw   (gnt_cw)
  );

  always_comb begin
    cw_op.wr   = 1'b1;
    cw_op.dev  = cw_dev;
    cw_op.rix  = cw_reg;
    cw_op.data = cw_data;
    sel_op     = gnt_mbx ? mbx_op : cw_op;
  end

  mbx_buscycle #(
    .SETUP_CLKS (SETUP_CLKS),
    .STROBE_MIN (STROBE_MIN),
    .HOLD_CLKS  (HOLD_CLKS)
  ) u_bus (
    .clk       (clk),
    .rst       (rst),
    .start     (gnt_mbx || gnt_cw),
    .start_op  (sel_op),
    .start_mbx (gnt_mbx),
    .bus_idle  (bus_idle),
    .done_mbx  (done_mbx),
    .done_rd   (done_rd),
    .done_cw   (done_cw),
    .rd_byte   (rd_byte),
    .lb_cs     (lb_cs),
    .lb_addr   (lb_addr),
    .lb_wr     (lb_wr),
    .lb_rd     (lb_rd),
    .lb_wait   (lb_wait),
    .lb_din    (lb_din),
    .lb_dout   (lb_dout),
    .lb_doe    (lb_doe)
  );

  assign cw_ack = done_cw;

  // R11: the acknowledge never fires for a mailbox transfer
  assert_ack_not_mbx_R11: assert property (@(posedge clk) disable iff (rst)
    cw_ack |-> !done_mbx);

  // R9: a waiting mailbox request is served before the next code write
  assert_mbx_before_cw_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_idle && busy) |=> (!bus_idle && lb_doe == mbx_op.wr));
endmodule

// File: tb/tb_mbx_bridge.sv
module tb_mbx_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        cw_req = 1'b0;
  logic [2:0]  cw_dev = '0;
  logic [2:0]  cw_reg = '0;
  logic [7:0]  cw_data = '0;
  logic        cw_ack;
  logic [7:0]  lb_cs;
  logic [2:0]  lb_addr;
  logic        lb_wr, lb_rd;
  logic        lb_wait = 1'b0;
  logic [7:0]  lb_din = '0;
  logic [7:0]  lb_dout;
  logic        lb_doe;

  always #10 clk = ~clk;

  mbx_bridge dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .cw_req(cw_req), .cw_dev(cw_dev), .cw_reg(cw_reg),
    .cw_data(cw_data), .cw_ack(cw_ack), .lb_cs(lb_cs), .lb_addr(lb_addr),
    .lb_wr(lb_wr), .lb_rd(lb_rd), .lb_wait(lb_wait), .lb_din(lb_din),
    .lb_dout(lb_dout), .lb_doe(lb_doe)
  );

  typedef struct packed {
    logic [31:0] word;
    logic [31:0] rb;
    logic [7:0]  waitc;
    logic [7:0]  din;
    logic [7:0]  cs;
    logic [2:0]  addr;
    logic        wr;
    logic [7:0]  dout;
    logic [7:0]  len;
  } vec_t;

  localparam vec_t VEC [0:5] = '{
    '{32'h0125_00A5, 32'h0125_00A5, 8'd0, 8'h00, 8'h04, 3'd5, 1'b1, 8'hA5, 8'd4},
    '{32'h0070_0000, 32'h0070_003C, 8'd0, 8'h3C, 8'h80, 3'd0, 1'b0, 8'h00, 8'd4},
    '{32'h0007_0011, 32'h0007_00C3, 8'd6, 8'hC3, 8'h01, 3'd7, 1'b0, 8'h00, 8'd7},
    '{32'h0153_005A, 32'h0153_005A, 8'd3, 8'h00, 8'h20, 3'd3, 1'b1, 8'h5A, 8'd4},
    '{32'hFF11_80FF, 32'h0111_00FF, 8'd4, 8'h00, 8'h02, 3'd1, 1'b1, 8'hFF, 8'd5},
    '{32'h0042_00EE, 32'h0042_0000, 8'd1, 8'h00, 8'h10, 3'd2, 1'b0, 8'h00, 8'd4}
  };

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // bus monitor state, updated only by tick()
  int       waitc = 0;
  int       m_len, m_setup, m_hold, m_doe_bad, m_ack, seq_n;
  bit       m_seen, prev_str;
  logic [7:0] m_cs, m_dout, seq [0:7];
  logic [2:0] m_addr;
  logic       m_wr, m_doe;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic mon_clear();
    m_len = 0; m_setup = 0; m_hold = 0; m_doe_bad = 0; m_ack = 0; seq_n = 0;
    m_seen = 0; m_cs = '0; m_addr = '0; m_wr = 0; m_dout = '0; m_doe = 0;
  endtask

  task automatic tick();
    bit str;
    @(negedge clk);
    str = lb_wr || lb_rd;
    if (str && !prev_str && seq_n < 8) begin
      seq[seq_n] = lb_cs;
      seq_n++;
    end
    if (str) begin
      if (m_len == 0) begin
        m_cs = lb_cs; m_addr = lb_addr; m_wr = lb_wr; m_dout = lb_dout; m_doe = lb_doe;
      end
      if (lb_rd && lb_doe) m_doe_bad++;
      lb_wait = (m_len < waitc);
      m_len++;
      m_seen = 1;
    end else begin
      lb_wait = 1'b0;
      if (lb_cs != '0) begin
        if (m_seen) m_hold++;
        else m_setup++;
      end
    end
    if (cw_ack) m_ack++;
    prev_str = str;
  endtask

  // one host write, then poll busy; returns clocks busy was seen high
  task automatic host_cmd(input logic [31:0] w, output int busy_n);
    host_wdata = w;
    host_wr = 1'b1;
    tick();
    host_wr = 1'b0;
    busy_n = 0;
    for (int i = 0; i < 200; i++) begin
      if (!host_rdata[25]) break;
      busy_n++;
      tick();
    end
  endtask

  initial begin
    int bn;
    prev_str = 0;
    mon_clear();
    repeat (4) tick();
    rst = 1'b0;
    tick();

    // R1: reset state
    chk(lb_cs == 8'h00, "R1 chip selects idle", {24'h0, lb_cs}, 32'h0);
    chk(!lb_wr && !lb_rd && !lb_doe, "R1 strobes idle",
        {29'h0, lb_wr, lb_rd, lb_doe}, 32'h0);
    chk(host_rdata == 32'h0, "R1 mailbox word", host_rdata, 32'h0);
    chk(!cw_ack, "R1 ack low", {31'h0, cw_ack}, 32'h0);

    // vector table walk
    for (int v = 0; v < 6; v++) begin
      mon_clear();
      waitc = int'(VEC[v].waitc);
      lb_din = VEC[v].din;
      host_wdata = VEC[v].word;
      host_wr = 1'b1;
      tick();
      host_wr = 1'b0;
      // R2: fields loaded and busy set one clock after the write
      chk(host_rdata[25] && host_rdata[24:16] == VEC[v].rb[24:16], "R2 fields+busy",
          host_rdata, {VEC[v].rb[31:26], 1'b1, VEC[v].rb[24:0]});
      bn = 0;
      for (int i = 0; i < 200; i++) begin
        if (!host_rdata[25]) break;
        bn++;
        tick();
      end
      chk(bn == int'(VEC[v].len) + 4, "R4 busy duration", bn, int'(VEC[v].len) + 4);
      chk(m_len == int'(VEC[v].len), "R5 strobe length", m_len, int'(VEC[v].len));
      chk(m_setup == 2 && m_hold == 1, "R5 setup/hold clocks",
          {m_setup[15:0], m_hold[15:0]}, 32'h0002_0001);
      chk(m_cs == VEC[v].cs && m_addr == VEC[v].addr, "R8 select and address",
          {m_cs, 5'h0, m_addr}, {VEC[v].cs, 5'h0, VEC[v].addr});
      if (VEC[v].wr)
        chk(m_wr && m_doe && m_dout == VEC[v].dout, "R6 write drive",
            {m_wr, m_doe, m_dout}, {2'b11, VEC[v].dout});
      else
        chk(!m_wr && m_doe_bad == 0 && !m_doe, "R6 read no drive",
            {m_wr, m_doe, m_doe_bad[7:0]}, 10'h0);
      chk(host_rdata == VEC[v].rb, VEC[v].wr ? "R2 readback" : "R7 read byte",
          host_rdata, VEC[v].rb);
      repeat (2) tick();
    end

    // R3: write during busy is ignored
    mon_clear();
    waitc = 2;
    host_wdata = 32'h0136_004D;
    host_wr = 1'b1;
    tick();
    host_wdata = 32'h0055_0011;
    tick();
    host_wr = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (!host_rdata[25]) break;
      tick();
    end
    chk(host_rdata == 32'h0136_004D, "R3 fields unchanged", host_rdata, 32'h0136_004D);
    chk(m_cs == 8'h08 && m_addr == 3'd6, "R3 original target",
        {m_cs, 5'h0, m_addr}, {8'h08, 8'h06});
    repeat (12) tick();
    chk(seq_n == 1, "R3 no extra transfer", seq_n, 1);

    // R9: mailbox inserted between code writes, R11 ack count
    mon_clear();
    waitc = 0;
    lb_din = 8'h96;
    cw_dev = 3'd6; cw_reg = 3'd4; cw_data = 8'h77;
    cw_req = 1'b1;
    for (int i = 0; i < 50; i++) begin
      tick();
      if (lb_wr) break;
    end
    host_cmd(32'h0032_0000, bn);
    chk(m_ack == 1, "R11 one ack before mailbox done", m_ack, 1);
    for (int i = 0; i < 50; i++) begin
      if (m_ack >= 2) break;
      tick();
    end
    cw_req = 1'b0;
    repeat (12) tick();
    chk(seq_n == 3 && seq[0] == 8'h40 && seq[1] == 8'h08 && seq[2] == 8'h40,
        "R9 transfer order", {seq_n[7:0], seq[0], seq[1], seq[2]}, 32'h0340_0840);
    chk(host_rdata == 32'h0032_0096, "R7 read between code writes",
        host_rdata, 32'h0032_0096);
    chk(m_ack == 2, "R11 ack per code write", m_ack, 2);

    // R10: same-clock tie goes to the mailbox
    mon_clear();
    host_wdata = 32'h0110_0012;
    host_wr = 1'b1;
    tick();
    host_wr = 1'b0;
    cw_req = 1'b1;
    for (int i = 0; i < 60; i++) begin
      if (m_ack >= 1) break;
      tick();
    end
    cw_req = 1'b0;
    repeat (12) tick();
    chk(seq_n == 2 && seq[0] == 8'h02 && seq[1] == 8'h40, "R10 mailbox first",
        {seq_n[7:0], seq[0], seq[1], 8'h0}, 32'h0202_4000);
    chk(m_ack == 1, "R11 no ack for mailbox", m_ack, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule